// File: doc/BRIEF.md
# Hart Interrupt Delivery Context

This block is the per-hart delivery stage of a wired interrupt controller working in direct mode. It takes in, for every interrupt source, a pending flag, an enable flag and a 32-bit routing word. The routing word names the hart that should service the source and gives the source a priority. Among the sources routed to its own hart index, the block selects one winner. It then drives a single external interrupt line towards that hart.

Software reaches the context through a small 32-bit read/write register bus. The registers are a domain configuration word, a delivery switch, a threshold, a side-effect-free view of the current winner and a claim port. Reading the claim port returns the winner and also sends a one-cycle clear pulse back to that source's pending logic. An interrupt handler can therefore keep claiming until it reads zero. Edge and level capture of the sources belong to the surrounding logic. That logic must clear the pending flag when it sees the pulse.

Top module: `hart_irq_ctx`

## Requirements
- R1: After reset the interrupt line is low and the configuration, delivery and threshold registers all read as zero.
- R2: A source can win only if its pending and enable flags are both set and bits 31:18 of its routing word equal the context's hart index; sources routed to another hart are never returned and never raise the line.
- R3: Among eligible sources the smallest priority number (routing word bits 7:0) wins; on equal priority the lower source number wins.
- R4: The threshold register (offset 0x14, bits 7:0) filters sources: at a non-zero value only priorities strictly below it qualify, zero disables filtering, and a value of 1 blocks every source.
- R5: A routing word with a priority field of 0 is treated as priority 1.
- R6: The interrupt line is high, one cycle after its inputs settle, exactly when the global enable (configuration register at offset 0x00, bit 8) is 1, the delivery register (offset 0x10, bit 0) is 1 and an eligible source exists.
- R7: Reading the claim register (offset 0x1C) or the top register (offset 0x18) returns the winner's source number in bits 25:16 and its priority in bits 7:0, independent of the two enable gates, and returns zero when no source is eligible.
- R8: A claim read that returns a non-zero winner drives, in the cycle its read data is valid, a one-hot clear pulse on the winning source's bit of the clear output; a claim read with no winner pulses nothing.
- R9: Reading the top register never produces a clear pulse.
- R10: Bit 2 of the configuration register (mode select) always reads 0 whatever is written; bit 8 reads back as written.
- R11: With the delivery register at 0 the line stays low even when an eligible source exists and the global enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_pend_i | input | NSRC | Pending flag per source, bit n is source n |
| src_en_i | input | NSRC | Enable flag per source, bit n is source n |
| src_tgt_i | input | NSRC*32 | Routing words, source n at bits [(n-1)*32 +: 32] |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | High the cycle after a read strobe |
| src_clr_o | output | NSRC | One-cycle clear pulse for the claimed source |
| ext_irq_o | output | 1 | External interrupt line to the hart |

## Verification
Directed patterns place two sources at the same priority with a third source at a worse priority. Another source at a better priority is routed to a different hart. This shows whether the arbiter breaks ties by source number and ignores foreign harts. A claim loop drains these sources one by one until zero is read, which separates the claim port's clear pulse from the side-effect-free top view. A threshold sweep over 1, 2, 5, 6 and 0 uses a source whose priority field is zero. It exposes off-by-one errors in the strict comparison and the zero-means-off rule. Randomised rounds of pending, enable, routing and threshold values then compare the top view and the interrupt line against an independent model of the selection rule.

// File: rtl/hart_irq_ctx_pkg.sv
package hart_irq_ctx_pkg;

  // Routing word layout
  localparam int TGT_W     = 32;
  localparam int HART_LSB  = 18;
  localparam int HART_W    = 14;
  localparam int PRIO_W    = 8;

  // Claim / top word layout
  localparam int ID_LSB    = 16;
  localparam int ID_W      = 10;

  // Register byte offsets
  localparam int OFF_CFG   = 'h00;
  localparam int OFF_DLV   = 'h10;
  localparam int OFF_THR   = 'h14;
  localparam int OFF_TOP   = 'h18;
  localparam int OFF_CLAIM = 'h1C;

  // Configuration register bit positions
  localparam int CFG_IE_BIT   = 8;
  localparam int CFG_MODE_BIT = 2;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } winner_t;

endpackage

// File: rtl/hart_irq_ctx_filter.sv
module hart_irq_ctx_filter
  import hart_irq_ctx_pkg::*;
#(
  parameter int NSRC     = 31,
  parameter int HART_IDX = 2
) (
  input  logic [NSRC:1]             src_pend_i,
  input  logic [NSRC:1]             src_en_i,
  input  logic [NSRC*TGT_W-1:0]     src_tgt_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [NSRC:1]             elig_o,
  output logic [NSRC*PRIO_W-1:0]    prio_o
);

  localparam int GAP_W = HART_LSB - PRIO_W;
  localparam logic [HART_W-1:0] OWN_HART = HART_W'(HART_IDX);

  logic thr_off;
  assign thr_off = (thr_i == '0);

  for (genvar g = 1; g <= NSRC; g++) begin : g_src
    logic [HART_W-1:0] hart;
    logic [PRIO_W-1:0] raw_prio;
    logic [PRIO_W-1:0] eff_prio;
    logic              unused_tgt;

    assign hart     = src_tgt_i[(g-1)*TGT_W + HART_LSB +: HART_W];
    assign raw_prio = src_tgt_i[(g-1)*TGT_W +: PRIO_W];
    assign unused_tgt = ^src_tgt_i[(g-1)*TGT_W + PRIO_W +: GAP_W];

    // a zero priority field is promoted to the lowest legal value
    assign eff_prio = (raw_prio == '0) ? PRIO_W'(1) : raw_prio;

    assign prio_o[(g-1)*PRIO_W +: PRIO_W] = eff_prio;
    assign elig_o[g] = src_pend_i[g] & src_en_i[g] & (hart == OWN_HART) &
                       (thr_off | (eff_prio < thr_i));
  end

endmodule

// File: rtl/hart_irq_ctx_arb.sv
module hart_irq_ctx_arb
  import hart_irq_ctx_pkg::*;
#(
  parameter int NSRC = 31
) (
  input  logic [NSRC:1]          elig_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output winner_t                win_o
);

  logic              best_vld;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;

  // linear scan from source 1 upward; strict compare keeps the lower
  // source number on a priority tie
  always_comb begin
    best_vld  = 1'b0;
    best_id   = '0;
    best_prio = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (elig_i[i] && (!best_vld || (prio_i[(i-1)*PRIO_W +: PRIO_W] < best_prio))) begin
        best_vld  = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio_i[(i-1)*PRIO_W +: PRIO_W];
      end
    end
  end

  assign win_o.id   = best_id;
  assign win_o.prio = best_prio;

endmodule

// File: rtl/hart_irq_ctx_regs.sv
module hart_irq_ctx_regs
  import hart_irq_ctx_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  winner_t           win_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [NSRC:1]     src_clr_o,
  output logic              cfg_ie_o,
  output logic              dlv_en_o,
  output logic [PRIO_W-1:0] thr_o
);

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_DLV   = ADDR_W'(OFF_DLV);
  localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(OFF_THR);
  localparam logic [ADDR_W-1:0] A_TOP   = ADDR_W'(OFF_TOP);
  localparam logic [ADDR_W-1:0] A_CLAIM = ADDR_W'(OFF_CLAIM);

  logic              ie_q, ie_d;
  logic              dlv_q, dlv_d;
  logic [PRIO_W-1:0] thr_q, thr_d;
  logic [31:0]       rdata_q, rdata_d;
  logic              rvalid_q, rd_req;
  logic [NSRC:1]     clr_q, clr_d;
  logic              wr_req, claim_hit;
  logic [31:0]       win_word;
  logic              unused_wdata;

  assign wr_req    = bus_req_i & bus_we_i;
  assign rd_req    = bus_req_i & ~bus_we_i;
  assign claim_hit = rd_req & (bus_addr_i == A_CLAIM) & (win_i.id != '0);
  assign win_word  = (32'(win_i.id) << ID_LSB) | 32'(win_i.prio);
  assign unused_wdata = ^{bus_wdata_i[31:PRIO_W]};

  // next-state for configuration registers
  always_comb begin
    ie_d  = ie_q;
    dlv_d = dlv_q;
    thr_d = thr_q;
    if (wr_req) begin
      unique case (bus_addr_i)
        A_CFG:   ie_d  = bus_wdata_i[CFG_IE_BIT];
        A_DLV:   dlv_d = bus_wdata_i[0];
        A_THR:   thr_d = bus_wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // read mux; the mode bit is never set in the returned word
  always_comb begin
    rdata_d = '0;
    unique case (bus_addr_i)
      A_CFG:   rdata_d[CFG_IE_BIT] = ie_q;
      A_DLV:   rdata_d[0] = dlv_q;
      A_THR:   rdata_d = 32'(thr_q);
      A_TOP:   rdata_d = win_word;
      A_CLAIM: rdata_d = win_word;
      default: rdata_d = '0;
    endcase
  end

  // one-hot clear decode for the claimed source
  always_comb begin
    clr_d = '0;
    for (int i = 1; i <= NSRC; i++) begin
      clr_d[i] = claim_hit & (win_i.id == ID_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q     <= 1'b0;
      dlv_q    <= 1'b0;
      thr_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      clr_q    <= '0;
    end else begin
      ie_q     <= ie_d;
      dlv_q    <= dlv_d;
      thr_q    <= thr_d;
      rvalid_q <= rd_req;
      clr_q    <= clr_d;
      if (rd_req) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign src_clr_o    = clr_q;
  assign cfg_ie_o     = ie_q;
  assign dlv_en_o     = dlv_q;
  assign thr_o        = thr_q;

endmodule

// File: rtl/hart_irq_ctx.sv
module hart_irq_ctx
  import hart_irq_ctx_pkg::*;
#(
  parameter int NSRC     = 31,
  parameter int HART_IDX = 2,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSRC:1]         src_pend_i,
  input  logic [NSRC:1]         src_en_i,
  input  logic [NSRC*32-1:0]    src_tgt_i,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  output logic                  bus_rvalid_o,
  output logic [NSRC:1]         src_clr_o,
  output logic                  ext_irq_o
);

  logic [NSRC:1]          elig;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  winner_t                win;
  logic                   cfg_ie;
  logic                   dlv_en;
  logic [PRIO_W-1:0]      thr_val;
  logic                   irq_d, irq_q;

  hart_irq_ctx_filter #(
    .NSRC     (NSRC),
    .HART_IDX (HART_IDX)
  ) u_filter (
    .src_pend_i (src_pend_i),
    .src_en_i   (src_en_i),
    .src_tgt_i  (src_tgt_i),
    .thr_i      (thr_val),
    .elig_o     (elig),
    .prio_o     (prio_flat)
  );

  hart_irq_ctx_arb #(
    .NSRC (NSRC)
  ) u_arb (
    .elig_i (elig),
    .prio_i (prio_flat),
    .win_o  (win)
  );

  hart_irq_ctx_regs #(
    .NSRC   (NSRC),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .win_i        (win),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .src_clr_o    (src_clr_o),
    .cfg_ie_o     (cfg_ie),
    .dlv_en_o     (dlv_en),
    .thr_o        (thr_val)
  );

  // both gates plus a live winner drive the line, registered once
  always_comb begin
    irq_d = cfg_ie & dlv_en & (win.id != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign ext_irq_o = irq_q;

endmodule

// File: rtl/hart_irq_ctx_chk.sv
module hart_irq_ctx_chk
  import hart_irq_ctx_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic              bus_rvalid_o,
  input logic [NSRC:1]     src_clr_o,
  input logic              ext_irq_o,
  input logic              cfg_ie,
  input logic              dlv_en,
  input logic [PRIO_W-1:0] thr_val
);

  // R8: at most one source is cleared per claim
  a_r8_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_clr_o));

  // R8/R9: a clear pulse only follows a claim read
  a_r9_clr_only_on_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_clr_o != '0) |-> $past(bus_req_i && !bus_we_i && bus_addr_i == ADDR_W'(OFF_CLAIM)));

  // R7: a zero readout never comes with a clear
  a_r7_zero_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rvalid_o && bus_rdata_o == '0) |-> (src_clr_o == '0));

  // R10: mode bit reads back as zero
  a_r10_mode_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rvalid_o && $past(bus_req_i && !bus_we_i && bus_addr_i == ADDR_W'(OFF_CFG)))
      |-> !bus_rdata_o[CFG_MODE_BIT]);

  // R4: threshold of one keeps the line low
  a_r4_thr_one_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_val == PRIO_W'(1)) |=> !ext_irq_o);

  // R6: global enable off keeps the line low
  a_r6_ie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ie |=> !ext_irq_o);

  // R11: delivery off keeps the line low
  a_r11_dlv_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dlv_en |=> !ext_irq_o);

endmodule

bind hart_irq_ctx hart_irq_ctx_chk #(
  .NSRC   (NSRC),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .src_clr_o    (src_clr_o),
  .ext_irq_o    (ext_irq_o),
  .cfg_ie       (cfg_ie),
  .dlv_en       (dlv_en),
  .thr_val      (thr_val)
);

// File: tb/hart_irq_ctx_tb.sv
`timescale 1ns/1ps
module hart_irq_ctx_tb;

  localparam int NSRC   = 15;
  localparam int HART   = 2;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_CFG = 8'h00, A_DLV = 8'h10, A_THR = 8'h14,
                         A_TOP = 8'h18, A_CLM = 8'h1C;

  logic              clk;
  logic              rst_n;
  logic [NSRC:1]     pend;
  logic [NSRC:1]     en;
  logic [31:0]       tgt [1:NSRC];
  logic [NSRC*32-1:0] tgt_flat;
  logic              req, we;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [NSRC:1]     clr;
  logic              irq;

  int checks = 0;
  int errors = 0;

  // bench shadow of software-visible state
  logic       m_ie, m_dlv;
  logic [7:0] m_thr;

  typedef struct {
    logic [31:0] data;
    int          clr_id;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always_comb begin
    for (int i = 1; i <= NSRC; i++) tgt_flat[(i-1)*32 +: 32] = tgt[i];
  end

  hart_irq_ctx #(.NSRC(NSRC), .HART_IDX(HART), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_pend_i(pend), .src_en_i(en),
    .src_tgt_i(tgt_flat), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .src_clr_o(clr), .ext_irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk_tgt(int hart, int prio);
    return {14'(hart), 10'b0, 8'(prio)};
  endfunction

  // selection rule from the requirements
  function automatic logic [31:0] model_top();
    int   bid = 0;
    int   bp  = 0;
    for (int i = 1; i <= NSRC; i++) begin
      int p = int'(tgt[i][7:0]);
      if (p == 0) p = 1;
      if (pend[i] && en[i] && int'(tgt[i][31:18]) == HART &&
          (m_thr == 0 || p < int'(m_thr)) && (bid == 0 || p < bp)) begin
        bid = i;
        bp  = p;
      end
    end
    return (32'(bid) << 16) | 32'(bp);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    if (a == A_CFG) m_ie = d[8];
    if (a == A_DLV) m_dlv = d[0];
    if (a == A_THR) m_thr = d[7:0];
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    idle(2);
  endtask

  // driver: pushes the expected read and clear into the scoreboard
  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    e.data   = exp;
    e.clr_id = (a == A_CLM) ? int'(exp[25:16]) : 0;
    e.tag    = tag;
    sb.push_back(e);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    idle(2);
  endtask

  task automatic chk_irq(string tag);
    logic [31:0] t;
    idle(2);
    t = model_top();
    check(32'(irq), 32'(m_ie & m_dlv & (t != 0)), tag);
  endtask

  // monitor: pops and compares results, and models the pending clear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected read data %h expected none", rdata);
      end else begin
        exp_t e;
        logic [NSRC:1] exp_clr;
        e = sb.pop_front();
        check(rdata, e.data, e.tag);
        exp_clr = '0;
        if (e.clr_id != 0) exp_clr[e.clr_id] = 1'b1;
        check(32'(clr), 32'(exp_clr), {e.tag, " clear R8"});
      end
    end
    for (int i = 1; i <= NSRC; i++) if (clr[i]) pend[i] = 1'b0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    pend = '0; en = '0;
    m_ie = 1'b0; m_dlv = 1'b0; m_thr = '0;
    for (int i = 1; i <= NSRC; i++) tgt[i] = mk_tgt(HART, 4);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check(32'(irq), 0, "R1 irq after reset");
    rd(A_CFG, 0, "R1 cfg reset");
    rd(A_DLV, 0, "R1 dlv reset");
    rd(A_THR, 0, "R1 thr reset");
    rd(A_CLM, 0, "R7 claim empty");

    // R10 enable bit readback, mode bit stays clear
    wr(A_CFG, 32'h0000_0104);
    rd(A_CFG, 32'h0000_0100, "R10 cfg readback");

    // directed arbitration set
    tgt[3]  = mk_tgt(HART, 5);
    tgt[7]  = mk_tgt(HART, 2);
    tgt[9]  = mk_tgt(HART, 2);
    tgt[12] = mk_tgt(1, 1);
    tgt[5]  = mk_tgt(HART, 0);
    en = '1;
    pend[3] = 1'b1; pend[7] = 1'b1; pend[9] = 1'b1; pend[12] = 1'b1;

    chk_irq("R11 delivery off");
    rd(A_TOP, model_top(), "R3 tie to lower id, R2 foreign hart");
    check(model_top(), (32'd7 << 16) | 32'd2, "R3 model sanity");
    wr(A_DLV, 1);
    rd(A_DLV, 1, "R1 dlv readback");
    chk_irq("R6 line high");
    rd(A_TOP, (32'd7 << 16) | 32'd2, "R9 top no clear");

    // claim loop drains hart sources
    rd(A_CLM, (32'd7 << 16) | 32'd2, "R8 claim first");
    rd(A_CLM, (32'd9 << 16) | 32'd2, "R8 claim second");
    rd(A_CLM, (32'd3 << 16) | 32'd5, "R8 claim third");
    rd(A_CLM, 0, "R7 claim zero, R2 hart mismatch left");
    chk_irq("R2 line low with foreign source");
    check(32'(pend[12]), 1, "R2 foreign pending untouched");

    // priority zero promotion and threshold sweep
    pend[3] = 1'b1; pend[5] = 1'b1;
    rd(A_TOP, (32'd5 << 16) | 32'd1, "R5 zero prio as one");
    wr(A_THR, 1);
    rd(A_THR, 1, "R4 thr readback");
    chk_irq("R4 thr one blocks line");
    rd(A_CLM, 0, "R4 thr one claim zero");
    wr(A_THR, 2);
    rd(A_TOP, (32'd5 << 16) | 32'd1, "R4 thr two passes prio one");
    wr(A_THR, 5);
    en[5] = 1'b0;
    rd(A_TOP, 0, "R4 equal prio blocked");
    chk_irq("R4 line low at equal");
    wr(A_THR, 6);
    rd(A_TOP, (32'd3 << 16) | 32'd5, "R4 below thr passes");
    wr(A_THR, 0);
    rd(A_TOP, (32'd3 << 16) | 32'd5, "R4 zero thr no filter");

    // global enable gate
    wr(A_CFG, 0);
    chk_irq("R6 global enable off");
    rd(A_TOP, (32'd3 << 16) | 32'd5, "R7 top independent of gates");
    wr(A_CFG, 32'h0000_0004);
    rd(A_CFG, 0, "R10 mode bit ignored");
    wr(A_CFG, 32'h0000_0100);

    // randomised rounds
    for (int r = 0; r < 24; r++) begin
      pend = NSRC'($urandom());
      en   = NSRC'($urandom());
      for (int i = 1; i <= NSRC; i++)
        tgt[i] = mk_tgt(int'($urandom_range(3, 1)), int'($urandom_range(7, 0)));
      wr(A_THR, 32'($urandom_range(8, 0)));
      rd(A_TOP, model_top(), "R3 random top");
      chk_irq("R6 random line");
    end
    rd(A_CLM, model_top(), "R8 random claim");
    idle(4);

    check(32'(sb.size()), 0, "R7 scoreboard drained");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule